// File: doc/BRIEF.md
# SCSI Bus Phase Change Detector

This block sits beside the initiator side of a SCSI protocol controller and watches the three phase lines that a target drives (I/O, C/D and MSG), together with BSY and REQ. While the controller is connected as an initiator, it notices when the target moves to a new information phase. It then raises a one-cycle bus service pulse, but only after the change has been qualified in two stages. In the first stage the new phase must hold steady for a settle window. In the second stage BSY must stay asserted for a hold window, which shows that the connection still exists.

The detected change is abandoned if the phase lines move during the settle window. If BSY falls during the hold window, a one-cycle connection-lost pulse is raised instead of bus service. A gating control restricts detection to cycles in which REQ is active. With the gate clear, a phase change is accepted without REQ. The latched phase output feeds the status register. It tracks the bus while the block is disconnected, and while connected it advances only when a change has been confirmed, so each change is reported once. All bus inputs are assumed to be synchronized already.

Top module: `phase_watch`

## Requirements
- R1: During reset, svc_o and lost_o are 0 and phase_o is 3'b000.
- R2: The phase is the 3-bit value {io_i, cd_i, msg_i}, with io_i at bit 2 and msg_i at bit 0. While conn_init is low, phase_o takes the bus phase sampled at each clock edge, and neither pulse output is raised.
- R3: Suppose a new phase (one that differs from phase_o) is first sampled at edge k, is sampled unchanged on SETTLE_CLKS consecutive edges (k through k+SETTLE_CLKS-1), and BSY is then sampled high on the next HOLD_CLKS edges. Then svc_o is high for exactly the one cycle that follows edge k+SETTLE_CLKS+HOLD_CLKS-1.
- R4: phase_o changes to the confirmed phase in the same cycle that svc_o is high. While conn_init stays high, phase_o changes at no other time, so an unchanged bus produces no second pulse.
- R5: If the phase lines differ from the candidate phase on any edge of the settle window, the detection is dropped without any pulse, and phase_o keeps its value.
- R6: If BSY is sampled low on any edge of the hold window, lost_o is high for one cycle, svc_o stays low, and phase_o keeps its value.
- R7: Phase-line movement during the hold window does not affect the pending detection. The pulse reports the candidate phase, and a later different phase is detected afterwards as a change of its own.
- R8: With req_gate low, a phase change is accepted whether or not REQ is asserted.
- R9: With req_gate high, a phase change is accepted only on an edge where req_i is high. While req_i stays low, a differing phase raises no pulse.
- R10: Dropping conn_init at any point of either window cancels the detection, and no pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conn_init | input | 1 | High while connected as initiator |
| req_gate | input | 1 | Accept phase changes only while REQ is active |
| bsy_i | input | 1 | Synchronized BSY |
| req_i | input | 1 | Synchronized REQ |
| io_i | input | 1 | Synchronized I/O phase line |
| cd_i | input | 1 | Synchronized C/D phase line |
| msg_i | input | 1 | Synchronized MSG phase line |
| svc_o | output | 1 | One-cycle bus service pulse |
| lost_o | output | 1 | One-cycle pulse: BSY fell during the hold window |
| phase_o | output | 3 | Latched phase {I/O, C/D, MSG} for status |

## Verification
The bench builds the block with its default windows of 12 settle clocks and 12 hold clocks. This makes the full 24-edge latency, a BSY drop inside the hold window and a phase glitch inside the settle window all reachable within a few dozen cycles. Random phase segments of 1 to 40 cycles, together with random BSY, REQ, gating and connection changes, run against an age-counting model in the bench. Short segments exercise abandonment, and long segments reach confirmation.

// File: rtl/phw_pkg.sv
package phw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HOLD   = 2'd2
  } phw_state_e;

  typedef logic [2:0] bus_phase_t;

  // Pack the three target-driven lines into one phase code.
  function automatic bus_phase_t pack_phase(input logic io, input logic cd, input logic msg);
    return {io, cd, msg};
  endfunction

  // True when a window counter holding cnt completes a window of len samples.
  function automatic logic win_last(input logic [31:0] cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

endpackage

// File: rtl/phw_change_det.sv
module phw_change_det
  import phw_pkg::*;
(
  input  logic       en,
  input  logic       gate,
  input  logic       req,
  input  bus_phase_t cur,
  input  bus_phase_t ref_ph,
  output logic       hit
);
  logic req_ok;

  assign req_ok = !gate || req;
  assign hit    = en && req_ok && (cur != ref_ph);
endmodule

// File: rtl/phw_window_ctr.sv
module phw_window_ctr
  import phw_pkg::*;
#(
  parameter int LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign last = win_last(32'(cnt_q), LEN);
endmodule

// File: rtl/phase_watch.sv
module phase_watch
  import phw_pkg::*;
#(
  parameter int SETTLE_CLKS = 12,
  parameter int HOLD_CLKS   = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conn_init,
  input  logic       req_gate,
  input  logic       bsy_i,
  input  logic       req_i,
  input  logic       io_i,
  input  logic       cd_i,
  input  logic       msg_i,
  output logic       svc_o,
  output logic       lost_o,
  output logic [2:0] phase_o
);
  // The detection edge is the first settle sample; the counter covers the rest.
  localparam int SETTLE_REST = SETTLE_CLKS - 1;

  phw_state_e st_q;
  bus_phase_t cur_ph, ref_q, cand_q;

  // Named internal events for the checker
  logic chg_seen, cand_match;
  logic settle_last, hold_last;
  logic settle_inc, hold_inc;
  logic abandon_ev, confirm_ev, lost_ev, svc_ev;
  logic svc_q, lost_q;

  assign cur_ph = pack_phase(io_i, cd_i, msg_i);

  phw_change_det u_det (
    .en     (conn_init && (st_q == ST_IDLE)),
    .gate   (req_gate),
    .req    (req_i),
    .cur    (cur_ph),
    .ref_ph (ref_q),
    .hit    (chg_seen)
  );

  assign cand_match = (cur_ph == cand_q);
  assign settle_inc = (st_q == ST_SETTLE) && conn_init && cand_match;
  assign abandon_ev = (st_q == ST_SETTLE) && conn_init && !cand_match;
  assign confirm_ev = settle_inc && settle_last;
  assign hold_inc   = (st_q == ST_HOLD) && conn_init && bsy_i;
  assign lost_ev    = (st_q == ST_HOLD) && conn_init && !bsy_i;
  assign svc_ev     = hold_inc && hold_last;

  phw_window_ctr #(.LEN(SETTLE_REST)) u_settle_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_q != ST_SETTLE),
    .inc   (settle_inc),
    .last  (settle_last)
  );

  phw_window_ctr #(.LEN(HOLD_CLKS)) u_hold_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_q != ST_HOLD),
    .inc   (hold_inc),
    .last  (hold_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ref_q  <= '0;
      cand_q <= '0;
      svc_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      svc_q  <= svc_ev;
      lost_q <= lost_ev;
      if (!conn_init) begin
        st_q  <= ST_IDLE;
        ref_q <= cur_ph;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            if (chg_seen) begin
              st_q   <= ST_SETTLE;
              cand_q <= cur_ph;
            end
          end
          ST_SETTLE: begin
            if (abandon_ev)      st_q <= ST_IDLE;
            else if (confirm_ev) st_q <= ST_HOLD;
          end
          ST_HOLD: begin
            if (lost_ev) begin
              st_q <= ST_IDLE;
            end else if (svc_ev) begin
              st_q  <= ST_IDLE;
              ref_q <= cand_q;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign svc_o   = svc_q;
  assign lost_o  = lost_q;
  assign phase_o = ref_q;
endmodule

// File: rtl/phw_chk.sv
module phw_chk
  import phw_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       conn_init,
  input logic       req_gate,
  input logic       req_i,
  input logic       bsy_i,
  input logic       svc_o,
  input logic       lost_o,
  input logic [2:0] phase_o,
  input phw_state_e st_q
);
  // R3
  svc_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_o |=> !svc_o);

  // R3
  svc_needs_bsy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_o |-> ($past(bsy_i) && $past(conn_init)));

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(svc_o && lost_o));

  // R6
  lost_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> !$past(bsy_i));

  // R4
  svc_moves_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_o |-> (phase_o != $past(phase_o)));

  // R4
  phase_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(conn_init) && !svc_o) |-> $stable(phase_o));

  // R9
  gate_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_IDLE) && req_gate && !req_i) |=> (st_q == ST_IDLE));

  // R10
  disc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conn_init |=> (!svc_o && !lost_o));
endmodule

bind phase_watch phw_chk u_phw_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conn_init (conn_init),
  .req_gate  (req_gate),
  .req_i     (req_i),
  .bsy_i     (bsy_i),
  .svc_o     (svc_o),
  .lost_o    (lost_o),
  .phase_o   (phase_o),
  .st_q      (st_q)
);

// File: tb/test_phase_watch.sv
module test_phase_watch;
  localparam int S = 12;
  localparam int H = 12;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, conn_init, req_gate, bsy_i, req_i;
  logic [2:0] ph;
  logic svc_o, lost_o;
  logic [2:0] phase_o;

  phase_watch #(.SETTLE_CLKS(S), .HOLD_CLKS(H)) i_phase_watch (
    .clk(clk), .rst_n(rst_n), .conn_init(conn_init), .req_gate(req_gate),
    .bsy_i(bsy_i), .req_i(req_i), .io_i(ph[2]), .cd_i(ph[1]), .msg_i(ph[0]),
    .svc_o(svc_o), .lost_o(lost_o), .phase_o(phase_o)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model: age counts qualifying samples since detection (0 = none)
  int m_age;
  logic [2:0] m_ref, m_cand;
  bit m_svc, m_lost;

  always @(posedge clk) begin
    m_svc  = 0;
    m_lost = 0;
    if (!rst_n) begin
      m_age = 0; m_ref = 3'd0; m_cand = 3'd0;
    end else if (!conn_init) begin
      m_age = 0; m_ref = ph;
    end else if (m_age == 0) begin
      if (ph != m_ref && (!req_gate || req_i)) begin m_cand = ph; m_age = 1; end
    end else if (m_age < S) begin
      if (ph != m_cand) m_age = 0; else m_age++;
    end else begin
      if (!bsy_i) begin m_lost = 1; m_age = 0; end
      else if (m_age == S + H - 1) begin m_svc = 1; m_ref = m_cand; m_age = 0; end
      else m_age++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(svc_o == m_svc, "R3 model svc_o", int'(svc_o), int'(m_svc));
      chk(lost_o == m_lost, "R6 model lost_o", int'(lost_o), int'(m_lost));
      chk(phase_o == m_ref, "R4 model phase_o", int'(phase_o), int'(m_ref));
    end
  end

  task automatic wait_svc(output int n);
    n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (svc_o || n >= 200) break;
    end
  endtask

  task automatic quiet(input int n, output bit any);
    any = 0;
    repeat (n) begin
      @(negedge clk);
      if (svc_o || lost_o) any = 1;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_errors++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    bit any;
    void'($urandom(32'd5519));
    rst_n = 0; conn_init = 0; req_gate = 0; bsy_i = 0; req_i = 0; ph = 3'd0;
    repeat (3) @(negedge clk);
    // R1
    chk(svc_o == 0, "R1 reset svc_o", int'(svc_o), 0);
    chk(lost_o == 0, "R1 reset lost_o", int'(lost_o), 0);
    chk(phase_o == 0, "R1 reset phase_o", int'(phase_o), 0);
    rst_n = 1;

    // R2: tracking while disconnected
    ph = 3'b010;
    @(negedge clk);
    chk(phase_o == 3'b010, "R2 tracks bus", int'(phase_o), 2);
    quiet(5, any);
    chk(!any, "R2 no pulse disconnected", int'(any), 0);

    // R3 / R8: full qualification without REQ
    bsy_i = 1; conn_init = 1;
    @(negedge clk);
    ph = 3'b011;
    wait_svc(n);
    chk(n == S + H, "R3 R8 latency", n, S + H);
    chk(phase_o == 3'b011, "R4 phase latched", int'(phase_o), 3);
    @(negedge clk);
    chk(svc_o == 0, "R3 pulse width", int'(svc_o), 0);
    quiet(40, any);
    chk(!any, "R4 single report", int'(any), 0);

    // R5: glitch back inside settle window
    ph = 3'b101;
    repeat (5) @(negedge clk);
    ph = 3'b011;
    quiet(60, any);
    chk(!any, "R5 abandoned", int'(any), 0);
    chk(phase_o == 3'b011, "R5 phase kept", int'(phase_o), 3);

    // R6: BSY drop in hold window
    ph = 3'b110;
    repeat (S + 3) @(negedge clk);
    bsy_i = 0;
    @(negedge clk);
    chk(lost_o == 1, "R6 lost pulse", int'(lost_o), 1);
    chk(svc_o == 0, "R6 no svc", int'(svc_o), 0);
    chk(phase_o == 3'b011, "R6 phase kept", int'(phase_o), 3);
    conn_init = 0; bsy_i = 1;
    @(negedge clk);
    chk(phase_o == 3'b110, "R2 resync", int'(phase_o), 6);

    // R7: movement during hold window
    conn_init = 1;
    @(negedge clk);
    ph = 3'b001;
    repeat (S + 2) @(negedge clk);
    ph = 3'b100;
    wait_svc(n);
    chk(n == H - 2, "R7 hold unaffected", n, H - 2);
    chk(phase_o == 3'b001, "R7 candidate reported", int'(phase_o), 1);
    wait_svc(n);
    chk(n == S + H, "R7 later change", n, S + H);
    chk(phase_o == 3'b100, "R7 later phase", int'(phase_o), 4);

    // R9: gating on REQ
    req_gate = 1; req_i = 0;
    ph = 3'b010;
    quiet(60, any);
    chk(!any, "R9 blocked without REQ", int'(any), 0);
    chk(phase_o == 3'b100, "R9 phase kept", int'(phase_o), 4);
    req_i = 1;
    wait_svc(n);
    chk(n == S + H, "R9 accepted with REQ", n, S + H);
    chk(phase_o == 3'b010, "R9 phase latched", int'(phase_o), 2);
    req_i = 0; req_gate = 0;

    // R10: disconnect mid window
    ph = 3'b111;
    repeat (S + 5) @(negedge clk);
    conn_init = 0;
    quiet(40, any);
    chk(!any, "R10 cancelled", int'(any), 0);
    chk(phase_o == 3'b111, "R10 tracks after drop", int'(phase_o), 7);

    // Random segments against the model
    for (int seg = 0; seg < 250; seg++) begin
      int len;
      len = 1 + int'($urandom % 40);
      ph = 3'($urandom);
      conn_init = ($urandom % 20) != 0;
      req_gate = $urandom % 2;
      for (int c = 0; c < len; c++) begin
        bsy_i = ($urandom % 16) != 0;
        req_i = $urandom % 2;
        @(negedge clk);
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule